// File: doc/BRIEF.md
# Handshake Parallel Port Unit

This unit is a peripheral on an 8-bit multiplexed address/data bus. A register address is captured from the low bus bits while the address latch strobe is high. A later read or write strobe then reaches one of three ports or the command/status location. Ports A and B are 8 bits wide, and each one is set by the command register as an input or an output port. Port C is 6 bits wide. It works as a plain input, as a plain output, or as handshake lines (interrupt request, buffer full, active-low strobe) for port A alone or for both 8-bit ports. Bus strobes and pins are sampled on the unit clock. A timer flag from outside is shown in the status word. Accesses to the timer byte locations are harmless: writes have no effect and reads return zero.

Each 8-bit port has its own handshake state machine with three states. EMPTY means the buffer is empty and no strobe is active. STROBE means the external strobe is low. FULL means the buffer holds data. On an input port the transitions are:

- EMPTY to STROBE when the strobe goes low.
- STROBE to FULL when the strobe goes high. The interrupt request is set if enabled.
- FULL to STROBE on a new strobe.
- FULL to EMPTY when the bus finishes reading the port.

On an output port the transitions are:

- EMPTY to FULL on a bus write, and STROBE to FULL on a bus write. Both clear the interrupt request.
- FULL to STROBE when the strobe goes low.
- STROBE to EMPTY when the strobe goes high. The interrupt request is set if enabled.

When port C is not configured to carry a port's handshake lines, that port's machine is forced to EMPTY and its interrupt request is cleared.

Top module: `hspio_unit`

## Requirements
- R1: Address bits [2:0] of `ad_in` are captured on every clock edge while `ale` is high. Codes are 0 command/status, 1 port A, 2 port B, 3 port C, 4 and 5 timer bytes. Writes to codes 4 to 7 change nothing, and reads of them return 0x00.
- R2: A write to code 0 loads the command register. A read of code 0 returns the status word.
- R3: Command bit 0 (port A) and bit 1 (port B) select output when 1. An output port drives its latch on its pins with all enables high, and a read returns the latch. An input port without handshake returns its live pins.
- R4: Command bits [3:2] select the port C mode. In mode 00 all six pins are inputs. In mode 11 all six are outputs driven from the port C latch. In mode 01, pin 0 is INTR-A, pin 1 is BF-A, pin 2 is the input STB-A (active low), and pins 3 to 5 are latch outputs. In mode 10, pins 0 to 2 are as in mode 01, pin 3 is INTR-B, pin 4 is BF-B, and pin 5 is the input STB-B. A port C read returns, for each pin, the driven value if it is an output and otherwise the pin.
- R5: The status word is bit0 INTR-A, bit1 BF-A, bit2 enable-A (command bit 4), bit3 INTR-B, bit4 BF-B, bit5 enable-B (command bit 5), bit6 `timer_flag`, and bit7 always 0.
- R6: Registers are reached only when `cs` is 1 and `io_sel` is 1. `ad_oe` is high only while both are 1 and `rd_n` is low. A write strobe under any other condition has no effect.
- R7: Strobed input: while the strobe is low, the port latch follows the pins and BF is 1. A read of the port, once it ends, returns the captured value and clears BF and INTR.
- R8: Strobed output: a bus write to the port sets BF and clears INTR. A low strobe clears BF, and the strobe's rising edge sets INTR.
- R9: INTR is set at a strobe's rising edge only when that port's interrupt enable is 1. Otherwise BF still behaves as stated.
- R10: Reset clears the command register. All ports then read as inputs with every output enable low, and all BF, INTR and enable flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch strobe |
| cs | input | 1 | Chip enable, active high |
| io_sel | input | 1 | 1 selects the I/O registers, 0 selects memory |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | 8 | Bus address/data into the unit |
| ad_out | output | 8 | Read data onto the bus |
| ad_oe | output | 1 | Bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 6 | Port C pin values |
| pc_out | output | 6 | Port C drive values |
| pc_oe | output | 6 | Port C drive enables |
| timer_flag | input | 1 | External timer flag shown in status bit 6 |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Input port under handshake.** A design that returns live pins instead of the strobed latch on such a port would read back a changed value after the strobe has gone high.
- **Interrupt request with enable off.** The bench strobes with the enable off. A design that ignores the enable would show INTR in the status word.
- **Output handshake sequence.** The bench runs write, strobe low, then strobe high. If BF is not cleared by the strobe, or INTR is not cleared by the next write, the status words differ.
- **Access gating.** Accesses with chip enable low, with memory selected, and to the timer locations are checked at the pins. Any leak would alter the port A drive value or raise `ad_oe`.

// File: rtl/hspio_pkg.sv
package hspio_pkg;
    localparam int DW  = 8;
    localparam int PCW = 6;
    localparam int AW  = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_PA   = 3'd1;
    localparam logic [AW-1:0] A_PB   = 3'd2;
    localparam logic [AW-1:0] A_PC   = 3'd3;

    typedef enum logic [1:0] {
        PCM_IN   = 2'b00,
        PCM_HSA  = 2'b01,
        PCM_HSAB = 2'b10,
        PCM_OUT  = 2'b11
    } pc_mode_t;

    typedef enum logic [1:0] {
        HS_EMPTY  = 2'd0,
        HS_STROBE = 2'd1,
        HS_FULL   = 2'd2
    } hs_state_t;
endpackage

// File: rtl/hspio_bus.sv
module hspio_bus #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic          cs,
    input  logic          io_sel,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr,
    output logic          sel,
    output logic          wr_evt,
    output logic          rd_end
);
    logic wr_q;
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            if (ale) addr <= addr_in;
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    assign sel    = cs & io_sel;
    assign wr_evt = sel & ~wr_n & wr_q;   // write strobe just went low
    assign rd_end = sel & rd_n & ~rd_q;   // read strobe just went high
endmodule

// File: rtl/hspio_hs.sv
module hspio_hs
    import hspio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dir_out,
    input  logic stb_n,
    input  logic inte,
    input  logic bus_wr,
    input  logic bus_rd_done,
    output logic bf,
    output logic intr,
    output logic load
);
    hs_state_t state, nxt;
    logic      intr_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_EMPTY;
            intr  <= 1'b0;
        end else begin
            state <= nxt;
            intr  <= intr_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        intr_nxt = intr;
        if (!en) begin
            nxt      = HS_EMPTY;
            intr_nxt = 1'b0;
        end else if (dir_out) begin
            unique case (state)
                HS_EMPTY: if (bus_wr) begin
                    nxt = HS_FULL; intr_nxt = 1'b0;
                end
                HS_FULL: begin
                    if (bus_wr) intr_nxt = 1'b0;
                    else if (!stb_n) nxt = HS_STROBE;
                end
                HS_STROBE: begin
                    if (bus_wr) begin
                        nxt = HS_FULL; intr_nxt = 1'b0;
                    end else if (stb_n) begin
                        nxt = HS_EMPTY; intr_nxt = inte;
                    end
                end
                default: nxt = HS_EMPTY;
            endcase
        end else begin
            unique case (state)
                HS_EMPTY: if (!stb_n) nxt = HS_STROBE;
                HS_STROBE: begin
                    if (stb_n) begin
                        nxt = HS_FULL; intr_nxt = inte;
                    end else if (bus_rd_done) intr_nxt = 1'b0;
                end
                HS_FULL: begin
                    if (!stb_n) nxt = HS_STROBE;
                    else if (bus_rd_done) begin
                        nxt = HS_EMPTY; intr_nxt = 1'b0;
                    end
                end
                default: nxt = HS_EMPTY;
            endcase
        end
    end

    always_comb begin
        bf   = dir_out ? (state == HS_FULL) : (state != HS_EMPTY);
        load = en & ~dir_out & ~stb_n;
    end
endmodule

// File: rtl/hspio_pcmux.sv
module hspio_pcmux
    import hspio_pkg::*;
(
    input  pc_mode_t       mode,
    input  logic [PCW-1:0] pc_latch,
    input  logic [1:0]     bf,
    input  logic [1:0]     intr,
    output logic [PCW-1:0] pc_out,
    output logic [PCW-1:0] pc_oe
);
    always_comb begin
        unique case (mode)
            PCM_IN: begin
                pc_out = pc_latch;
                pc_oe  = 6'b000000;
            end
            PCM_OUT: begin
                pc_out = pc_latch;
                pc_oe  = 6'b111111;
            end
            PCM_HSA: begin
                pc_out = {pc_latch[5:3], 1'b0, bf[0], intr[0]};
                pc_oe  = 6'b111011;
            end
            default: begin
                pc_out = {1'b0, bf[1], intr[1], 1'b0, bf[0], intr[0]};
                pc_oe  = 6'b011011;
            end
        endcase
    end
endmodule

// File: rtl/hspio_unit.sv
module hspio_unit
    import hspio_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ale,
    input  logic           cs,
    input  logic           io_sel,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [DW-1:0]  ad_in,
    output logic [DW-1:0]  ad_out,
    output logic           ad_oe,
    input  logic [DW-1:0]  pa_in,
    output logic [DW-1:0]  pa_out,
    output logic [DW-1:0]  pa_oe,
    input  logic [DW-1:0]  pb_in,
    output logic [DW-1:0]  pb_out,
    output logic [DW-1:0]  pb_oe,
    input  logic [PCW-1:0] pc_in,
    output logic [PCW-1:0] pc_out,
    output logic [PCW-1:0] pc_oe,
    input  logic           timer_flag
);
    logic [AW-1:0]  addr;
    logic           sel, wr_evt, rd_end;
    logic [5:0]     cmd_q;
    logic [DW-1:0]  pa_q, pb_q;
    logic [PCW-1:0] pc_q;
    pc_mode_t       pc_mode;
    logic [1:0]     hs_en, dir, inte, stb_n, bus_wr, rd_done, bf, intr, load;
    logic           bf_a, intr_a, bf_b, intr_b;
    logic [DW-1:0]  rdata;

    hspio_bus #(.AW(AW)) u_bus (
        .clk(clk), .rst(rst), .ale(ale), .cs(cs), .io_sel(io_sel),
        .rd_n(rd_n), .wr_n(wr_n), .addr_in(ad_in[AW-1:0]),
        .addr(addr), .sel(sel), .wr_evt(wr_evt), .rd_end(rd_end)
    );

    assign pc_mode = pc_mode_t'(cmd_q[3:2]);
    assign dir     = cmd_q[1:0];
    assign inte    = cmd_q[5:4];
    assign hs_en   = {pc_mode == PCM_HSAB, pc_mode == PCM_HSA || pc_mode == PCM_HSAB};
    assign stb_n   = {pc_in[5], pc_in[2]};
    assign bus_wr  = {wr_evt && addr == A_PB, wr_evt && addr == A_PA};
    assign rd_done = {rd_end && addr == A_PB, rd_end && addr == A_PA};

    for (genvar p = 0; p < 2; p++) begin : g_hs
        hspio_hs u_hs (
            .clk(clk), .rst(rst), .en(hs_en[p]), .dir_out(dir[p]),
            .stb_n(stb_n[p]), .inte(inte[p]), .bus_wr(bus_wr[p]),
            .bus_rd_done(rd_done[p]), .bf(bf[p]), .intr(intr[p]),
            .load(load[p])
        );
    end

    assign bf_a   = bf[0];
    assign intr_a = intr[0];
    assign bf_b   = bf[1];
    assign intr_b = intr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            pa_q  <= '0;
            pb_q  <= '0;
            pc_q  <= '0;
        end else begin
            if (wr_evt && addr == A_CTRL) cmd_q <= ad_in[5:0];
            if (bus_wr[0])   pa_q <= ad_in;
            else if (load[0]) pa_q <= pa_in;
            if (bus_wr[1])   pb_q <= ad_in;
            else if (load[1]) pb_q <= pb_in;
            if (wr_evt && addr == A_PC) pc_q <= ad_in[PCW-1:0];
        end
    end

    hspio_pcmux u_pcmux (
        .mode(pc_mode), .pc_latch(pc_q), .bf(bf), .intr(intr),
        .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {1'b0, timer_flag, inte[1], bf_b, intr_b, inte[0], bf_a, intr_a};
            A_PA:    rdata = (dir[0] || hs_en[0]) ? pa_q : pa_in;
            A_PB:    rdata = (dir[1] || hs_en[1]) ? pb_q : pb_in;
            A_PC:    rdata = {{(DW-PCW){1'b0}}, (pc_oe & pc_out) | (~pc_oe & pc_in)};
            default: rdata = '0;
        endcase
    end

    assign ad_out = rdata;
    assign ad_oe  = sel & ~rd_n;
    assign pa_out = pa_q;
    assign pb_out = pb_q;
    assign pa_oe  = {DW{dir[0]}};
    assign pb_oe  = {DW{dir[1]}};
endmodule

// File: rtl/hspio_chk.sv
module hspio_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       io_sel,
    input logic       rd_n,
    input logic       ad_oe,
    input logic       bf_a,
    input logic       intr_a,
    input logic       intr_b,
    input logic       inte_a,
    input logic       inte_b,
    input logic       dir_a,
    input logic [5:0] pc_in,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_oe,
    input logic [5:0] pc_oe
);
    // R6: the bus is driven only for a selected I/O read
    assert_bus_drive_R6: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (cs && io_sel && !rd_n));

    // R9: an interrupt request appears only with its enable set
    assert_intr_a_gated_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_a) |-> $past(inte_a));
    assert_intr_b_gated_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_b) |-> $past(inte_b));

    // R7: on an input port the buffer fills only after a low strobe
    assert_bf_from_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(bf_a) && !dir_a) |-> !$past(pc_in[2]));

    // R10: leaving reset, every port is an input and flags are clear
    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 6'h00
                        && !bf_a && !intr_a));
endmodule

bind hspio_unit hspio_chk u_chk (
    .clk(clk), .rst(rst), .cs(cs), .io_sel(io_sel), .rd_n(rd_n),
    .ad_oe(ad_oe), .bf_a(bf_a), .intr_a(intr_a), .intr_b(intr_b),
    .inte_a(cmd_q[4]), .inte_b(cmd_q[5]), .dir_a(cmd_q[0]),
    .pc_in(pc_in), .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/tb_hspio_unit.sv
module tb_hspio_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0, cs = 1'b1, io_sel = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out, pa_out, pa_oe, pb_out, pb_oe;
    logic       ad_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic [5:0] pc_in = 6'h3F, pc_out, pc_oe;
    logic       timer_flag = 1'b0;
    int         checks = 0, errors = 0, cyc = 0;

    always #5 clk = ~clk;

    hspio_unit dut (
        .clk(clk), .rst(rst), .ale(ale), .cs(cs), .io_sel(io_sel),
        .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
        .pc_out(pc_out), .pc_oe(pc_oe), .timer_flag(timer_flag)
    );

    // fields: cmd, wrA, wrB, wrC, pinA, pinB, pinC, expA, expB, expC, expCoe
    localparam logic [87:0] VECS [0:5] = '{
        {8'h00, 8'h11, 8'h22, 8'h33, 8'hA5, 8'h5A, 8'h2D, 8'hA5, 8'h5A, 8'h2D, 8'h00},
        {8'h03, 8'h3C, 8'hC3, 8'h15, 8'h00, 8'hFF, 8'h3F, 8'h3C, 8'hC3, 8'h3F, 8'h00},
        {8'h0D, 8'h81, 8'h7E, 8'h2A, 8'hFF, 8'h99, 8'h15, 8'h81, 8'h99, 8'h2A, 8'h3F},
        {8'h0E, 8'h44, 8'h66, 8'h3F, 8'h12, 8'h00, 8'h00, 8'h12, 8'h66, 8'h3F, 8'h3F},
        {8'h04, 8'h77, 8'h88, 8'h38, 8'h90, 8'h0F, 8'h3F, 8'h77, 8'h0F, 8'h3C, 8'h3B},
        {8'h09, 8'h5E, 8'h19, 8'h00, 8'h00, 8'hE7, 8'h3F, 8'h5E, 8'h19, 8'h26, 8'h1B}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                             input logic c, input logic io);
        @(negedge clk); cs = c; io_sel = io; ale = 1'b1; ad_in = {5'b0, a};
        @(negedge clk); ale = 1'b0; ad_in = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs = 1'b1; io_sel = 1'b1;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic c, input logic io,
                            output logic [7:0] d, output logic oe);
        @(negedge clk); cs = c; io_sel = io; ale = 1'b1; ad_in = {5'b0, a};
        @(negedge clk); ale = 1'b0; rd_n = 1'b0;
        @(negedge clk); d = ad_out; oe = ad_oe; rd_n = 1'b1;
        @(negedge clk); cs = 1'b1; io_sel = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        logic oe;
        bus_read(a, 1'b1, 1'b1, d, oe);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(1);

        // R10 reset state, R5 status layout
        check("R10 pa_oe after reset", pa_oe, 8'h00);
        check("R10 pb_oe after reset", pb_oe, 8'h00);
        check("R10 pc_oe after reset", {2'b0, pc_oe}, 8'h00);
        rd(3'd0, d); check("R10 status after reset", d, 8'h00);
        timer_flag = 1'b1;
        rd(3'd0, d); check("R5 timer flag in status bit6", d, 8'h40);
        timer_flag = 1'b0;

        // R1 R2 R3 R4 vector table
        for (int i = 0; i < 6; i++) begin
            logic [87:0] v;
            v = VECS[i];
            @(negedge clk); pa_in = v[55:48]; pb_in = v[47:40]; pc_in = v[37:32];
            bus_write(3'd0, v[87:80], 1'b1, 1'b1);
            bus_write(3'd1, v[79:72], 1'b1, 1'b1);
            bus_write(3'd2, v[71:64], 1'b1, 1'b1);
            bus_write(3'd3, v[63:56], 1'b1, 1'b1);
            rd(3'd1, d); check($sformatf("R3 port A read v%0d", i), d, v[31:24]);
            rd(3'd2, d); check($sformatf("R3 port B read v%0d", i), d, v[23:16]);
            rd(3'd3, d); check($sformatf("R4 port C read v%0d", i), d, v[15:8]);
            check($sformatf("R4 pc_oe v%0d", i), {2'b0, pc_oe}, v[7:0]);
            check($sformatf("R3 pa_oe v%0d", i), pa_oe, {8{v[80]}});
            check($sformatf("R3 pb_oe v%0d", i), pb_oe, {8{v[81]}});
            if (v[80]) check($sformatf("R3 pa_out v%0d", i), pa_out, v[79:72]);
        end

        // R10 reset again mid-configuration
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0; pc_in = 6'h3F;
        check("R10 pa_oe cleared", pa_oe, 8'h00);
        rd(3'd0, d); check("R10 status cleared", d, 8'h00);

        // R7 R9 strobed input on port A, interrupt enabled
        bus_write(3'd0, 8'h14, 1'b1, 1'b1);
        @(negedge clk); pa_in = 8'hC7; pc_in[2] = 1'b0;
        idle(2);
        rd(3'd0, d); check("R7 BF-A set while strobe low", d, 8'h06);
        @(negedge clk); pc_in[2] = 1'b1;
        idle(2);
        @(negedge clk); pa_in = 8'h00;
        rd(3'd0, d); check("R9 INTR-A set at strobe rise", d, 8'h07);
        check("R4 pc_out INTR-A BF-A pins", {6'b0, pc_out[1:0]}, 8'h03);
        rd(3'd1, d); check("R7 port A returns strobed value", d, 8'hC7);
        rd(3'd0, d); check("R7 read clears BF-A and INTR-A", d, 8'h04);

        // R9 strobe with interrupt disabled
        bus_write(3'd0, 8'h04, 1'b1, 1'b1);
        @(negedge clk); pa_in = 8'h3E; pc_in[2] = 1'b0;
        idle(2);
        @(negedge clk); pc_in[2] = 1'b1;
        idle(2);
        rd(3'd0, d); check("R9 no INTR-A when disabled", d, 8'h02);
        rd(3'd1, d); check("R7 port A strobed value", d, 8'h3E);

        // R8 strobed output on port B
        bus_write(3'd0, 8'h2A, 1'b1, 1'b1);
        bus_write(3'd2, 8'h5D, 1'b1, 1'b1);
        rd(3'd0, d); check("R8 write sets BF-B", d, 8'h30);
        check("R8 pb_out driven", pb_out, 8'h5D);
        @(negedge clk); pc_in[5] = 1'b0;
        idle(2);
        rd(3'd0, d); check("R8 low strobe clears BF-B", d, 8'h20);
        @(negedge clk); pc_in[5] = 1'b1;
        idle(2);
        rd(3'd0, d); check("R8 strobe rise sets INTR-B", d, 8'h28);
        check("R4 pc_out INTR-B pin", {7'b0, pc_out[3]}, 8'h01);
        bus_write(3'd2, 8'h11, 1'b1, 1'b1);
        rd(3'd0, d); check("R8 write clears INTR-B", d, 8'h30);

        // R6 R1 access gating and timer locations
        bus_write(3'd0, 8'h03, 1'b1, 1'b1);
        bus_write(3'd1, 8'h55, 1'b1, 1'b1);
        bus_write(3'd1, 8'hAA, 1'b0, 1'b1);
        check("R6 write ignored with cs low", pa_out, 8'h55);
        bus_write(3'd1, 8'hAA, 1'b1, 1'b0);
        check("R6 write ignored for memory select", pa_out, 8'h55);
        bus_read(3'd1, 1'b0, 1'b1, d, oe);
        check("R6 no drive with cs low", {7'b0, oe}, 8'h00);
        bus_write(3'd4, 8'hFF, 1'b1, 1'b1);
        bus_write(3'd5, 8'hFF, 1'b1, 1'b1);
        rd(3'd4, d); check("R1 timer low byte reads zero", d, 8'h00);
        rd(3'd5, d); check("R1 timer high byte reads zero", d, 8'h00);
        rd(3'd0, d); check("R1 timer writes leave status", d, 8'h00);
        check("R1 timer writes leave port A", pa_out, 8'h55);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule